// File: doc/BRIEF.md
# Delay-Slot Branch Resume Resolver

This block serves the exception path of a 32-bit RISC core whose branches carry one delay slot. When an exception hits the instruction in a delay slot, recovery software needs the address at which execution resumes once the branch has been settled. The block takes the address of the branch, its 32-bit instruction word, the two register operands that the word names, the floating-point status word and the DSP position field. From these it works out the resume address, the link-register write that the branch would have made, and three fault flags.

The block decodes the following kinds of control transfer:

- register jumps, with or without link;
- absolute 26-bit jumps, with or without link;
- equality and inequality compare branches;
- signed tests against zero, with or without link;
- the "likely" encodings, which resolve exactly like their plain forms;
- branches on a floating-point condition bit;
- a branch on the DSP position field.

A two-state machine handles the request. In `S_IDLE` the block waits. A request moves it to `S_DONE` (transition IDLE→DONE) and captures the result. A further request in `S_DONE` keeps it there with a fresh result (transition DONE→DONE). A cycle with no request returns it to `S_IDLE` (transition DONE→IDLE). `vld_o` is high exactly while the state is `S_DONE`.

Top module: `brnpc_resolver`

## Requirements
- R1: Each cycle with `req_i` high produces `vld_o` high in the following cycle, and only then. Back-to-back requests give back-to-back valid cycles. After reset, `vld_o` and every result output read zero.
- R2: If `pc_i[1:0]` is not zero, the block raises `misalign_o`. It returns `npc_o = pc_i` with `link_we_o` low, `illegal_o` low and `nobranch_o` low. This takes priority over every other outcome.
- R3: For a conditional branch (equality, sign test, floating-point or DSP), the result depends on whether the branch is taken. If taken, `npc_o = pc + 4 + (sign-extended instr[15:0] << 2)`. If not taken, `npc_o = pc + 8`.
- R4: Opcode (`instr[31:26]`) 4 and 20 branch when the rs and rt operands are equal. Opcode 5 and 21 branch when they differ.
- R5: The following sign tests compare the rs operand with zero as a signed value:
  - opcode 6 and 22 branch when it is ≤ 0;
  - opcode 7 and 23 branch when it is > 0;
  - opcode 1 with rt field (`instr[20:16]`) 0 or 2 branches when it is < 0;
  - opcode 1 with rt field 1 or 3 branches when it is ≥ 0.
- R6: Opcode 1 with rt field 16/18 behaves like the < 0 test, and rt field 17/19 like the ≥ 0 test. Each of these also writes `pc + 8` to register 31, whether or not the branch is taken.
- R7: Opcode 2 is an absolute jump and opcode 3 is the same jump with a link write of `pc + 8` to register 31. For both, `npc_o = {(pc+4)[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 0 with function field (`instr[5:0]`) 8 sets `npc_o` to the rs operand. Function field 9 does the same and also writes `pc + 8` to the register named by `instr[15:11]`.
- R9: Opcode 17 with `instr[25:21] = 8` is a floating-point condition branch. With `cc = instr[20:18]`, it tests status bit 23 when cc is 0 and bit 24+cc otherwise. `instr[16]` = 1 branches when that bit is set; 0 branches when it is clear. `instr[17]` has no effect.
- R10: Opcode 1 with rt field 28 branches when `dsp_pos_i >= 32`. When the block is built with `HAS_DSP = 0`, this instruction instead raises `illegal_o` with `npc_o = pc_i` and no link write.
- R11: A register field of 0 reads as zero whatever the operand input carries. A link write that names register 0 is suppressed (`link_we_o` low).
- R12: Any other encoding sets `nobranch_o`, with `npc_o = pc_i` and no link write. This includes other function codes under opcode 0, other rt codes under opcode 1, and opcode 17 with `instr[25:21] != 8`.
- R13: At most one of the three fault flags is high. Whenever `link_we_o` is low, `link_idx_o` and `link_val_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Resolve request, one cycle per branch |
| pc_i | input | 32 | Address of the branch instruction |
| instr_i | input | 32 | Branch instruction word |
| rs_val_i | input | 32 | Value of the register named by `instr[25:21]` |
| rt_val_i | input | 32 | Value of the register named by `instr[20:16]` |
| fpstat_i | input | 32 | Floating-point condition/status word |
| dsp_pos_i | input | 6 | DSP position field |
| vld_o | output | 1 | Result valid, one cycle after each request |
| npc_o | output | 32 | Resume address |
| link_we_o | output | 1 | Link register write enable |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value |
| misalign_o | output | 1 | Branch address misaligned |
| illegal_o | output | 1 | DSP branch without DSP support |
| nobranch_o | output | 1 | Instruction is not a branch |

## Verification
The target path and the link path fire in the same result for every linking branch. Either of them can also collide with the misalignment fault, which must win and silence both. The bench provokes this collision by sending every opcode, including all linking forms, at addresses whose low two bits are 1, 2 and 3. It judges the outcome by requiring a raised misalign flag, a resume address equal to the input address and a cleared link write. A second instance built without DSP support receives the same stimulus, so the illegal fault and a taken DSP condition meet in the same request.

// File: rtl/brnpc_pkg.sv
`timescale 1ns/1ps
package brnpc_pkg;

    parameter int XLEN       = 32;
    parameter int REGW       = 5;
    parameter int IMMW       = 16;
    parameter int JTGTW      = 26;
    parameter int OPW        = 6;
    parameter int FNW        = 6;
    parameter int FCC_N      = 8;
    parameter int FCC_BASE   = 23;
    parameter int DSP_POSW   = 6;
    parameter int DSP_THRESH = 32;
    parameter int LINK_REG   = 31;

    localparam int FCCW   = $clog2(FCC_N);
    localparam int SEXT_W = XLEN - IMMW - 2;

    // primary opcode values
    localparam logic [OPW-1:0] OP_GRP_R     = 6'd0;
    localparam logic [OPW-1:0] OP_GRP_SIGN  = 6'd1;
    localparam logic [OPW-1:0] OP_JABS      = 6'd2;
    localparam logic [OPW-1:0] OP_JABS_LNK  = 6'd3;
    localparam logic [OPW-1:0] OP_EQ        = 6'd4;
    localparam logic [OPW-1:0] OP_NE        = 6'd5;
    localparam logic [OPW-1:0] OP_LEZ       = 6'd6;
    localparam logic [OPW-1:0] OP_GTZ       = 6'd7;
    localparam logic [OPW-1:0] OP_FPU       = 6'd17;
    localparam logic [OPW-1:0] OP_EQ_LK     = 6'd20;
    localparam logic [OPW-1:0] OP_NE_LK     = 6'd21;
    localparam logic [OPW-1:0] OP_LEZ_LK    = 6'd22;
    localparam logic [OPW-1:0] OP_GTZ_LK    = 6'd23;

    // function codes under OP_GRP_R
    localparam logic [FNW-1:0] FN_JREG      = 6'd8;
    localparam logic [FNW-1:0] FN_JREG_LNK  = 6'd9;

    // rt-field codes under OP_GRP_SIGN
    localparam logic [REGW-1:0] RI_LTZ      = 5'd0;
    localparam logic [REGW-1:0] RI_GEZ      = 5'd1;
    localparam logic [REGW-1:0] RI_LTZ_LK   = 5'd2;
    localparam logic [REGW-1:0] RI_GEZ_LK   = 5'd3;
    localparam logic [REGW-1:0] RI_LTZ_AL   = 5'd16;
    localparam logic [REGW-1:0] RI_GEZ_AL   = 5'd17;
    localparam logic [REGW-1:0] RI_LTZ_ALK  = 5'd18;
    localparam logic [REGW-1:0] RI_GEZ_ALK  = 5'd19;
    localparam logic [REGW-1:0] RI_DSPPOS   = 5'd28;

    // rs-field selector for condition branches under OP_FPU
    localparam logic [REGW-1:0] FPU_BR_SEL  = 5'd8;

    typedef enum logic [3:0] {
        K_NONE,
        K_JREG,
        K_JABS,
        K_EQ,
        K_NE,
        K_LEZ,
        K_GTZ,
        K_LTZ,
        K_GEZ,
        K_FPC,
        K_DSP
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic              link;
        logic [REGW-1:0]   link_idx;
        logic              fp_true;
        logic [FCCW-1:0]   fcc;
    } dec_t;

    typedef struct packed {
        logic              misal;
        logic              ill;
        logic              nobr;
        logic              lwe;
        logic [REGW-1:0]   lidx;
        logic [XLEN-1:0]   lval;
        logic [XLEN-1:0]   npc;
    } res_t;

    typedef enum logic {
        S_IDLE,
        S_DONE
    } state_e;

endpackage

// File: rtl/brnpc_decode.sv
`timescale 1ns/1ps
module brnpc_decode
    import brnpc_pkg::*;
(
    input  logic [OPW-1:0]  op_i,
    input  logic [REGW-1:0] rs_i,
    input  logic [REGW-1:0] rt_i,
    input  logic [REGW-1:0] rd_i,
    input  logic [FNW-1:0]  fn_i,
    output dec_t            dec_o
);

    always_comb begin
        dec_o          = '0;
        dec_o.kind     = K_NONE;
        unique case (op_i)
            OP_GRP_R: begin
                if (fn_i == FN_JREG) begin
                    dec_o.kind = K_JREG;
                end else if (fn_i == FN_JREG_LNK) begin
                    dec_o.kind     = K_JREG;
                    dec_o.link     = 1'b1;
                    dec_o.link_idx = rd_i;
                end
            end
            OP_GRP_SIGN: begin
                unique case (rt_i)
                    RI_LTZ, RI_LTZ_LK: dec_o.kind = K_LTZ;
                    RI_GEZ, RI_GEZ_LK: dec_o.kind = K_GEZ;
                    RI_LTZ_AL, RI_LTZ_ALK: begin
                        dec_o.kind     = K_LTZ;
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = REGW'(LINK_REG);
                    end
                    RI_GEZ_AL, RI_GEZ_ALK: begin
                        dec_o.kind     = K_GEZ;
                        dec_o.link     = 1'b1;
                        dec_o.link_idx = REGW'(LINK_REG);
                    end
                    RI_DSPPOS: dec_o.kind = K_DSP;
                    default:   dec_o.kind = K_NONE;
                endcase
            end
            OP_JABS: dec_o.kind = K_JABS;
            OP_JABS_LNK: begin
                dec_o.kind     = K_JABS;
                dec_o.link     = 1'b1;
                dec_o.link_idx = REGW'(LINK_REG);
            end
            OP_EQ,  OP_EQ_LK:  dec_o.kind = K_EQ;
            OP_NE,  OP_NE_LK:  dec_o.kind = K_NE;
            OP_LEZ, OP_LEZ_LK: dec_o.kind = K_LEZ;
            OP_GTZ, OP_GTZ_LK: dec_o.kind = K_GTZ;
            OP_FPU: begin
                if (rs_i == FPU_BR_SEL) begin
                    dec_o.kind    = K_FPC;
                    dec_o.fp_true = rt_i[0];
                    dec_o.fcc     = rt_i[REGW-1 -: FCCW];
                end
            end
            default: dec_o.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/brnpc_cond.sv
`timescale 1ns/1ps
module brnpc_cond
    import brnpc_pkg::*;
(
    input  kind_e               kind_i,
    input  logic [XLEN-1:0]     rs_v_i,
    input  logic [XLEN-1:0]     rt_v_i,
    input  logic [XLEN-1:0]     fpstat_i,
    input  logic                fp_true_i,
    input  logic [FCCW-1:0]     fcc_i,
    input  logic [DSP_POSW-1:0] dsp_pos_i,
    output logic                taken_o
);

    logic [FCC_N-1:0] cc_bits;
    logic             rs_neg;
    logic             rs_zero;
    logic             cc_sel;

    // condition bit 0 sits apart from the others; bit FCC_BASE+1 is skipped
    for (genvar g = 0; g < FCC_N; g++) begin : g_fcc
        localparam int IDX = (g == 0) ? FCC_BASE : FCC_BASE + 1 + g;
        assign cc_bits[g] = fpstat_i[IDX];
    end

    logic unused_fp;
    assign unused_fp = ^{fpstat_i[FCC_BASE-1:0], fpstat_i[FCC_BASE+1]};

    assign rs_neg  = rs_v_i[XLEN-1];
    assign rs_zero = (rs_v_i == '0);
    assign cc_sel  = cc_bits[fcc_i];

    always_comb begin
        unique case (kind_i)
            K_EQ:    taken_o = (rs_v_i == rt_v_i);
            K_NE:    taken_o = (rs_v_i != rt_v_i);
            K_LEZ:   taken_o = rs_neg | rs_zero;
            K_GTZ:   taken_o = ~rs_neg & ~rs_zero;
            K_LTZ:   taken_o = rs_neg;
            K_GEZ:   taken_o = ~rs_neg;
            K_FPC:   taken_o = fp_true_i ? cc_sel : ~cc_sel;
            K_DSP:   taken_o = (dsp_pos_i >= DSP_POSW'(DSP_THRESH));
            default: taken_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/brnpc_target.sv
`timescale 1ns/1ps
module brnpc_target
    import brnpc_pkg::*;
(
    input  logic [XLEN-1:0]  pc_i,
    input  logic [JTGTW-1:0] jfield_i,
    input  logic [XLEN-1:0]  rs_v_i,
    input  kind_e            kind_i,
    input  logic             taken_i,
    output logic [XLEN-1:0]  npc_o,
    output logic [XLEN-1:0]  link_val_o
);

    logic [IMMW-1:0] imm;
    logic [XLEN-1:0] off;
    logic [XLEN-1:0] seq;
    logic [XLEN-1:0] fall;
    logic [XLEN-1:0] abs_tgt;

    assign imm     = jfield_i[IMMW-1:0];
    assign off     = {{SEXT_W{imm[IMMW-1]}}, imm, 2'b00};
    assign seq     = pc_i + XLEN'(4);
    assign fall    = pc_i + XLEN'(8);
    assign abs_tgt = {seq[XLEN-1:JTGTW+2], jfield_i, 2'b00};

    assign link_val_o = fall;

    always_comb begin
        unique case (kind_i)
            K_NONE:  npc_o = pc_i;
            K_JREG:  npc_o = rs_v_i;
            K_JABS:  npc_o = abs_tgt;
            default: npc_o = taken_i ? (seq + off) : fall;
        endcase
    end

endmodule

// File: rtl/brnpc_resolver.sv
`timescale 1ns/1ps
module brnpc_resolver
    import brnpc_pkg::*;
#(
    parameter bit HAS_DSP = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_i,
    input  logic [XLEN-1:0]     pc_i,
    input  logic [XLEN-1:0]     instr_i,
    input  logic [XLEN-1:0]     rs_val_i,
    input  logic [XLEN-1:0]     rt_val_i,
    input  logic [XLEN-1:0]     fpstat_i,
    input  logic [DSP_POSW-1:0] dsp_pos_i,
    output logic                vld_o,
    output logic [XLEN-1:0]     npc_o,
    output logic                link_we_o,
    output logic [REGW-1:0]     link_idx_o,
    output logic [XLEN-1:0]     link_val_o,
    output logic                misalign_o,
    output logic                illegal_o,
    output logic                nobranch_o
);

    logic [OPW-1:0]  f_op;
    logic [REGW-1:0] f_rs;
    logic [REGW-1:0] f_rt;
    logic [REGW-1:0] f_rd;
    logic [FNW-1:0]  f_fn;

    assign f_op = instr_i[XLEN-1 -: OPW];
    assign f_rs = instr_i[XLEN-OPW-1 -: REGW];
    assign f_rt = instr_i[XLEN-OPW-REGW-1 -: REGW];
    assign f_rd = instr_i[XLEN-OPW-2*REGW-1 -: REGW];
    assign f_fn = instr_i[FNW-1:0];

    // register zero is hardwired
    logic [XLEN-1:0] rs_v;
    logic [XLEN-1:0] rt_v;
    assign rs_v = (f_rs == '0) ? '0 : rs_val_i;
    assign rt_v = (f_rt == '0) ? '0 : rt_val_i;

    dec_t            dec;
    logic            taken;
    logic [XLEN-1:0] tgt_npc;
    logic [XLEN-1:0] tgt_link;

    brnpc_decode u_decode (
        .op_i  (f_op),
        .rs_i  (f_rs),
        .rt_i  (f_rt),
        .rd_i  (f_rd),
        .fn_i  (f_fn),
        .dec_o (dec)
    );

    brnpc_cond u_cond (
        .kind_i    (dec.kind),
        .rs_v_i    (rs_v),
        .rt_v_i    (rt_v),
        .fpstat_i  (fpstat_i),
        .fp_true_i (dec.fp_true),
        .fcc_i     (dec.fcc),
        .dsp_pos_i (dsp_pos_i),
        .taken_o   (taken)
    );

    brnpc_target u_target (
        .pc_i       (pc_i),
        .jfield_i   (instr_i[JTGTW-1:0]),
        .rs_v_i     (rs_v),
        .kind_i     (dec.kind),
        .taken_i    (taken),
        .npc_o      (tgt_npc),
        .link_val_o (tgt_link)
    );

    // result selection with fault priority
    logic misal;
    logic dsp_bad;
    res_t res_d;
    res_t res_q;

    assign misal = |pc_i[1:0];

    generate
        if (HAS_DSP) begin : g_dsp_on
            assign dsp_bad = 1'b0;
        end else begin : g_dsp_off
            assign dsp_bad = (dec.kind == K_DSP);
        end
    endgenerate

    always_comb begin
        res_d     = '0;
        res_d.npc = pc_i;
        if (misal) begin
            res_d.misal = 1'b1;
        end else if (dec.kind == K_NONE) begin
            res_d.nobr = 1'b1;
        end else if (dsp_bad) begin
            res_d.ill = 1'b1;
        end else begin
            res_d.npc = tgt_npc;
            if (dec.link && (dec.link_idx != '0)) begin
                res_d.lwe  = 1'b1;
                res_d.lidx = dec.link_idx;
                res_d.lval = tgt_link;
            end
        end
    end

    // state machine
    state_e state_q;
    state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  state_d = req_i ? S_DONE : S_IDLE;
            S_DONE:  state_d = req_i ? S_DONE : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (req_i) begin
            res_q <= res_d;
        end
    end

    assign vld_o      = (state_q == S_DONE);
    assign npc_o      = res_q.npc;
    assign link_we_o  = res_q.lwe;
    assign link_idx_o = res_q.lidx;
    assign link_val_o = res_q.lval;
    assign misalign_o = res_q.misal;
    assign illegal_o  = res_q.ill;
    assign nobranch_o = res_q.nobr;

endmodule

// File: rtl/brnpc_checker.sv
`timescale 1ns/1ps
module brnpc_checker
    import brnpc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_i,
    input logic [XLEN-1:0] pc_i,
    input logic            vld_o,
    input logic [XLEN-1:0] npc_o,
    input logic            link_we_o,
    input logic [REGW-1:0] link_idx_o,
    input logic [XLEN-1:0] link_val_o,
    input logic            misalign_o,
    input logic            illegal_o,
    input logic            nobranch_o
);

    AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> vld_o); // R1
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (!rst_n) !req_i |=> !vld_o); // R1
    AST_MISALIGN_WINS: assert property (@(posedge clk) disable iff (!rst_n) (req_i && (pc_i[1:0] != 2'b00)) |=> (misalign_o && !link_we_o && !illegal_o && !nobranch_o && (npc_o == $past(pc_i)))); // R2
    AST_ALIGNED_NO_MISAL: assert property (@(posedge clk) disable iff (!rst_n) (req_i && (pc_i[1:0] == 2'b00)) |=> !misalign_o); // R2
    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (!link_we_o || (link_val_o == $past(pc_i) + XLEN'(8)))); // R6
    AST_LINK_NOT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) link_we_o |-> (link_idx_o != '0)); // R11
    AST_NOBRANCH_HOLDS_PC: assert property (@(posedge clk) disable iff (!rst_n) req_i |=> (!(nobranch_o || illegal_o) || (npc_o == $past(pc_i) && !link_we_o))); // R12
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $countones({misalign_o, illegal_o, nobranch_o}) <= 1); // R13
    AST_QUIET_LINK: assert property (@(posedge clk) disable iff (!rst_n) !link_we_o |-> (link_idx_o == '0 && link_val_o == '0)); // R13

endmodule

bind brnpc_resolver brnpc_checker u_brnpc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .pc_i       (pc_i),
    .vld_o      (vld_o),
    .npc_o      (npc_o),
    .link_we_o  (link_we_o),
    .link_idx_o (link_idx_o),
    .link_val_o (link_val_o),
    .misalign_o (misalign_o),
    .illegal_o  (illegal_o),
    .nobranch_o (nobranch_o)
);

// File: tb/test_brnpc_resolver.sv
`timescale 1ns/1ps
module test_brnpc_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [31:0] pc = '0;
    logic [31:0] ins = '0;
    logic [31:0] rsv = '0;
    logic [31:0] rtv = '0;
    logic [31:0] fps = '0;
    logic [5:0]  pos = '0;

    logic        vld_a, lwe_a, mis_a, ill_a, nob_a;
    logic [31:0] npc_a, lval_a;
    logic [4:0]  lidx_a;
    logic        vld_b, lwe_b, mis_b, ill_b, nob_b;
    logic [31:0] npc_b, lval_b;
    logic [4:0]  lidx_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    brnpc_resolver #(.HAS_DSP(1'b1)) i_brnpc_resolver (
        .clk(clk), .rst_n(rst_n), .req_i(req), .pc_i(pc), .instr_i(ins),
        .rs_val_i(rsv), .rt_val_i(rtv), .fpstat_i(fps), .dsp_pos_i(pos),
        .vld_o(vld_a), .npc_o(npc_a), .link_we_o(lwe_a), .link_idx_o(lidx_a),
        .link_val_o(lval_a), .misalign_o(mis_a), .illegal_o(ill_a), .nobranch_o(nob_a)
    );

    brnpc_resolver #(.HAS_DSP(1'b0)) i_brnpc_resolver_nodsp (
        .clk(clk), .rst_n(rst_n), .req_i(req), .pc_i(pc), .instr_i(ins),
        .rs_val_i(rsv), .rt_val_i(rtv), .fpstat_i(fps), .dsp_pos_i(pos),
        .vld_o(vld_b), .npc_o(npc_b), .link_we_o(lwe_b), .link_idx_o(lidx_b),
        .link_val_o(lval_b), .misalign_o(mis_b), .illegal_o(ill_b), .nobranch_o(nob_b)
    );

    // {vld, misal, ill, nobr, lwe, lidx, lval, npc}
    function automatic logic [73:0] obs_a();
        return {vld_a, mis_a, ill_a, nob_a, lwe_a, lidx_a, lval_a, npc_a};
    endfunction

    function automatic logic [73:0] obs_b();
        return {vld_b, mis_b, ill_b, nob_b, lwe_b, lidx_b, lval_b, npc_b};
    endfunction

    function automatic logic [73:0] model(input logic [31:0] p, input logic [31:0] w,
                                          input logic [31:0] ra, input logic [31:0] rb,
                                          input logic [31:0] f, input logic [5:0] dp,
                                          input bit dsp_on);
        logic [5:0]  op  = w[31:26];
        logic [4:0]  fs  = w[25:21];
        logic [4:0]  ft  = w[20:16];
        logic [4:0]  fd  = w[15:11];
        logic [5:0]  fn  = w[5:0];
        logic [31:0] a   = (fs == 0) ? 32'd0 : ra;
        logic [31:0] b   = (ft == 0) ? 32'd0 : rb;
        logic [31:0] hit = p + 32'd4 + {{14{w[15]}}, w[15:0], 2'b00};
        logic [31:0] mis = p + 32'd8;
        logic [31:0] np;
        int          cls = 0; // 0 none, 1 conditional, 2 direct target
        bit          tk  = 0;
        bit          lk  = 0;
        logic [4:0]  li  = 5'd31;
        int          bi;
        if (p[1:0] != 2'b00) return {1'b1, 3'b100, 1'b0, 5'd0, 32'd0, p};
        case (op)
            6'd0: begin
                if (fn == 6'd8 || fn == 6'd9) begin
                    cls = 2; np = a;
                    if (fn == 6'd9) begin lk = 1; li = fd; end
                end
            end
            6'd1: begin
                if (ft inside {5'd0, 5'd2, 5'd16, 5'd18}) begin cls = 1; tk = $signed(a) < 0; end
                if (ft inside {5'd1, 5'd3, 5'd17, 5'd19}) begin cls = 1; tk = $signed(a) >= 0; end
                if (ft >= 5'd16 && ft <= 5'd19) lk = 1;
                if (ft == 5'd28) begin
                    if (!dsp_on) return {1'b1, 3'b010, 1'b0, 5'd0, 32'd0, p};
                    cls = 1; tk = (dp >= 6'd32);
                end
            end
            6'd2, 6'd3: begin
                cls = 2;
                np  = {(p + 32'd4) >> 28, w[25:0], 2'b00};
                lk  = (op == 6'd3);
            end
            6'd4, 6'd20: begin cls = 1; tk = (a == b); end
            6'd5, 6'd21: begin cls = 1; tk = (a != b); end
            6'd6, 6'd22: begin cls = 1; tk = $signed(a) <= 0; end
            6'd7, 6'd23: begin cls = 1; tk = $signed(a) > 0; end
            6'd17: begin
                if (fs == 5'd8) begin
                    bi  = (ft[4:2] == 0) ? 23 : 24 + int'(ft[4:2]);
                    cls = 1;
                    tk  = ft[0] ? f[bi] : !f[bi];
                end
            end
            default: cls = 0;
        endcase
        if (cls == 0) return {1'b1, 3'b001, 1'b0, 5'd0, 32'd0, p};
        if (cls == 1) np = tk ? hit : mis;
        if (lk && li != 0) return {1'b1, 3'b000, 1'b1, li, p + 32'd8, np};
        return {1'b1, 3'b000, 1'b0, 5'd0, 32'd0, np};
    endfunction

    task automatic check(input string tag, input logic [73:0] act, input logic [73:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (pc=%h instr=%h)", tag, act, exp, pc, ins);
        end
    endtask

    task automatic run(input logic [31:0] p, input logic [31:0] w, input logic [31:0] ra,
                       input logic [31:0] rb, input logic [31:0] f, input logic [5:0] dp,
                       input string tag);
        @(negedge clk);
        pc = p; ins = w; rsv = ra; rtv = rb; fps = f; pos = dp; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        check(tag, obs_a(), model(p, w, ra, rb, f, dp, 1'b1));
        check(tag, obs_b(), model(p, w, ra, rb, f, dp, 1'b0));
    endtask

    function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] s,
                                         input logic [4:0] t, input logic [15:0] imm);
        return {op, s, t, imm};
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    logic [31:0] vals [6] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0000_1230};
    logic [15:0] imms [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFE};

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 reset", obs_a(), 74'd0);
        check("R1 reset", obs_b(), 74'd0);

        // R4 / R3: equality compares with rs and rt fields nonzero
        foreach (imms[k]) begin
            for (int o = 0; o < 4; o++) begin
                logic [5:0] op = (o == 0) ? 6'd4 : (o == 1) ? 6'd5 : (o == 2) ? 6'd20 : 6'd21;
                run(32'h0040_1000, mk_i(op, 5'd3, 5'd4, imms[k]), 32'h55, 32'h55, 0, 0, "R4 R3");
                run(32'h0040_1000, mk_i(op, 5'd3, 5'd4, imms[k]), 32'h55, 32'h56, 0, 0, "R4 R3");
                run(32'h0000_0008, mk_i(op, 5'd3, 5'd0, imms[k]), 32'h0, 32'h77, 0, 0, "R4 R11");
            end
        end

        // R5 / R6: sign tests, plain, likely and linking
        foreach (vals[v]) begin
            for (int o = 6; o <= 7; o++) begin
                run(32'h1000_0100, mk_i(6'(o), 5'd9, 5'd0, 16'h0010), vals[v], 0, 0, 0, "R5");
                run(32'h1000_0100, mk_i(6'(o + 16), 5'd9, 5'd0, 16'hFFF0), vals[v], 0, 0, 0, "R5");
            end
            for (int t = 0; t < 4; t++) begin
                run(32'h2000_0200, mk_i(6'd1, 5'd9, 5'(t), 16'h0020), vals[v], 0, 0, 0, "R5");
                run(32'h2000_0200, mk_i(6'd1, 5'd9, 5'(t + 16), 16'hFFE0), vals[v], 0, 0, 0, "R6");
            end
        end

        // R7: absolute jumps, including carry into the kept top bits
        for (int o = 2; o <= 3; o++) begin
            run(32'h0000_0000, {6'(o), 26'h3FF_FFFF}, 0, 0, 0, 0, "R7");
            run(32'h1FFF_FFFC, {6'(o), 26'h000_0001}, 0, 0, 0, 0, "R7");
            run(32'hFFFF_FFFC, {6'(o), 26'h123_4567}, 0, 0, 0, 0, "R7");
            run(32'h8000_1000, {6'(o), 26'h2AA_AAAA}, 0, 0, 0, 0, "R7");
        end

        // R8 / R11: register jumps over every destination index
        for (int d = 0; d < 32; d++) begin
            run(32'h0000_4000, {6'd0, 5'd7, 5'd0, 5'(d), 5'd0, 6'd9}, 32'hABCD_0000, 0, 0, 0, "R8 R11");
            run(32'h0000_4000, {6'd0, 5'd0, 5'd0, 5'(d), 5'd0, 6'd8}, 32'hABCD_0000, 0, 0, 0, "R8 R11");
        end

        // R9: floating-point condition branches over every rt code
        for (int t = 0; t < 32; t++) begin
            for (int b = 22; b < 32; b++) begin
                run(32'h0300_0000, mk_i(6'd17, 5'd8, 5'(t), 16'h0040), 0, 0, 32'd1 << b, 0, "R9");
            end
            run(32'h0300_0000, mk_i(6'd17, 5'd8, 5'(t), 16'h8004), 0, 0, 32'hFFFF_FFFF, 0, "R9");
        end

        // R10: DSP position test on both configurations
        for (int p = 0; p < 64; p++) begin
            run(32'h0500_0000, mk_i(6'd1, 5'd0, 5'd28, 16'h0100), 0, 0, 0, 6'(p), "R10");
        end

        // R2 / R13: misalignment colliding with every opcode, linking forms included
        for (int m = 1; m < 4; m++) begin
            for (int o = 0; o < 64; o++) begin
                run(32'h0001_0000 | 32'(m), mk_i(6'(o), 5'd5, 5'd17, 16'h0009), 32'h80, 32'h80, 32'hFFFF_FFFF, 6'd40, "R2 R13");
            end
        end

        // R12: everything else, against the full opcode/sub-code space
        for (int o = 0; o < 64; o++) begin
            run(32'h0000_0100, mk_i(6'(o), 5'd2, 5'd6, 16'h0004), 32'h4, 32'h5, 32'h0080_0000, 6'd3, "R12 R3");
        end
        for (int t = 0; t < 32; t++) begin
            run(32'h0000_0200, mk_i(6'd1, 5'd2, 5'(t), 16'h0004), 32'h4, 0, 0, 6'd50, "R12 R5");
            run(32'h0000_0200, mk_i(6'd17, 5'(t), 5'd1, 16'h0004), 0, 0, 32'h0080_0000, 0, "R12 R9");
        end
        for (int f = 0; f < 64; f++) begin
            run(32'h0000_0300, {6'd0, 5'd2, 5'd3, 5'd31, 5'd0, 6'(f)}, 32'h1000, 0, 0, 0, "R12 R8");
        end

        // R1: back-to-back requests, then a single-cycle drop of valid
        @(negedge clk);
        pc = 32'h0000_1000; ins = {6'd2, 26'h10}; req = 1'b1;
        @(negedge clk);
        check("R1 b2b first", obs_a(), model(32'h0000_1000, {6'd2, 26'h10}, 0, 0, 0, 0, 1'b1));
        pc = 32'h0000_2000; ins = {6'd3, 26'h20};
        @(negedge clk);
        req = 1'b0;
        check("R1 b2b second", obs_a(), model(32'h0000_2000, {6'd3, 26'h20}, 0, 0, 0, 0, 1'b1));
        @(negedge clk);
        checks++;
        if (vld_a !== 1'b0) begin
            errors++;
            $display("FAIL R1 pulse: got vld=%b expected vld=0", vld_a);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule